// File: doc/BRIEF.md
# Register-mapped ADC conversion controller

This block is the digital side of a small monitoring converter. It sits behind a byte-wide host register bus and keeps the settings of the converter front end. It sequences each conversion and returns the result as two bytes. The bus has an address, a write strobe, a read strobe, write data and read data. Writing the input-select register stores a channel number and an attenuator flag and starts a conversion immediately.

In this block an internal down-counter takes the place of the analog converter. After a fixed number of clock cycles it captures a 10-bit sample from an input port. A completion flag travels in bit 0 of the low result byte, so a host can poll a single register and get both the status and the low result bits. A start request that arrives during a conversion restarts it, and the completion flag then waits for the later request. The block also maps a fixed 32-bit signature as four read-only bytes. It has a write-triggered register that clears the sequencer and the stored settings.

Top module: `adc_regfile_ctrl`

## Requirements
- R1: After power-on reset, the input-select register (0x00) and the low result byte (0x01) read as 0x00, chan_o and atten_o are 0, and no conversion runs.
- R2: A write to 0x00 stores write-data bits 3:0 as the channel and bit 4 as the attenuator flag. These drive chan_o and atten_o and read back at 0x00 as {3'b000, atten, chan}. The same write starts a conversion.
- R3: The completion flag (bit 0 of 0x01) reads 0 from the cycle after a start write. It becomes 1 exactly CONV_CYCLES clock edges after the edge that took the start write.
- R4: The result is captured from sample_i on the final cycle of a conversion. The stored result does not change while a conversion runs.
- R5: Address 0x01 reads {result[6:0], done} and address 0x02 reads {5'b00000, result[9:7]}.
- R6: A start write during a running conversion restarts it. The flag stays 0 until CONV_CYCLES edges after the later write, and the result is the sample present at that later completion.
- R7: Addresses 0x04, 0x05, 0x06 and 0x07 read signature bits 7:0, 15:8, 23:16 and 31:24 respectively.
- R8: A write to a signature address changes no register and starts no conversion.
- R9: Any write to 0x03 produces a one-cycle internal clear pulse, registered one edge after the write. The pulse clears the flag, the counter and the input-select register and aborts a running conversion. The stored result is kept.
- R10: Reads of 0x03 and of every address from 0x08 upward return 0x00.
- R11: Read data is registered. rdata_o takes the addressed value at the edge that samples rd_i and holds it while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| sample_i | input | 10 | Converter sample, captured at the end of a conversion |
| chan_o | output | 4 | Selected input channel |
| atten_o | output | 1 | Attenuator enable |

## Verification
The assertions check the following on every cycle:
- a start write clears the flag on the next cycle;
- the flag rises only out of a running conversion;
- the stored result is steady during a conversion;
- a reset-register write empties the sequencer and the settings two edges later;
- unmapped reads return zero, and read data holds without a strobe.

The bench scenarios cover what a per-cycle property cannot show: the exact completion edge, capture of the sample at the last cycle rather than at the start, and the flag being held off past the earlier request's finish on a restart. They also cover the stored result surviving a reset-register write, and the absence of any effect from signature writes.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
    localparam int BUS_W     = 8;
    localparam int CHAN_W    = 4;
    localparam int SEL_W     = CHAN_W + 1;
    localparam int SIG_BYTES = 4;
    localparam int SIG_W     = SIG_BYTES * BUS_W;

    localparam logic [BUS_W-1:0] A_SEL    = 8'h00;
    localparam logic [BUS_W-1:0] A_RES_LO = 8'h01;
    localparam logic [BUS_W-1:0] A_RES_HI = 8'h02;
    localparam logic [BUS_W-1:0] A_CLEAR  = 8'h03;
    localparam logic [BUS_W-1:0] A_SIG0   = 8'h04;
    localparam logic [BUS_W-1:0] A_UNMAP  = A_SIG0 + BUS_W'(SIG_BYTES);

    typedef struct packed {
        logic              atten;
        logic [CHAN_W-1:0] chan;
    } sel_t;
endpackage

// File: rtl/adcr_sig_rom.sv
module adcr_sig_rom
    import adcr_pkg::*;
#(
    parameter logic [SIG_W-1:0] SIG_VALUE = 32'h5EC7_91A3
) (
    output logic [SIG_BYTES-1:0][BUS_W-1:0] bytes_o
);
    for (genvar g = 0; g < SIG_BYTES; g++) begin : g_byte
        assign bytes_o[g] = SIG_VALUE[g*BUS_W +: BUS_W];
    end
endmodule

// File: rtl/adcr_seq.sv
module adcr_seq #(
    parameter int CONV_CYCLES = 64,
    parameter int RES_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             clr_i,
    input  logic [RES_W-1:0] sample_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [RES_W-1:0] res;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
            s_d.done = 1'b0;
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_LOAD;
            s_d.done = 1'b0;
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.res  = sample_i;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o   = s_q.busy;
    assign done_o   = s_q.done;
    assign result_o = s_q.res;
endmodule

// File: rtl/adcr_regs.sv
module adcr_regs
    import adcr_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [BUS_W-1:0]                addr_i,
    input  logic                            wr_i,
    input  logic                            rd_i,
    input  logic [BUS_W-1:0]                wdata_i,
    input  logic                            done_i,
    input  logic [RES_W-1:0]                result_i,
    input  logic [SIG_BYTES-1:0][BUS_W-1:0] sig_i,
    output logic [BUS_W-1:0]                rdata_o,
    output sel_t                            sel_o,
    output logic                            start_o,
    output logic                            clr_o
);
    typedef struct packed {
        sel_t             sel;
        logic             clr;
        logic [BUS_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic [BUS_W-1:0] rd_mux;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[BUS_W-1:SEL_W];

    always_comb begin
        rd_mux = '0;
        if (addr_i == A_SEL)    rd_mux = BUS_W'(r_q.sel);
        if (addr_i == A_RES_LO) rd_mux = {result_i[BUS_W-2:0], done_i};
        if (addr_i == A_RES_HI) rd_mux = BUS_W'(result_i >> (BUS_W - 1));
        for (int i = 0; i < SIG_BYTES; i++) begin
            if (addr_i == A_SIG0 + BUS_W'(i)) rd_mux = sig_i[i];
        end
    end

    assign start_o = wr_i && (addr_i == A_SEL) && !r_q.clr;

    always_comb begin
        r_d     = r_q;
        r_d.clr = wr_i && (addr_i == A_CLEAR);
        if (r_q.clr) begin
            r_d.sel = '0;
        end else if (start_o) begin
            r_d.sel = sel_t'(wdata_i[SEL_W-1:0]);
        end
        if (rd_i) r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata_o = r_q.rdata;
    assign sel_o   = r_q.sel;
    assign clr_o   = r_q.clr;
endmodule

// File: rtl/adc_regfile_ctrl.sv
module adc_regfile_ctrl
    import adcr_pkg::*;
#(
    parameter int               CONV_CYCLES = 64,
    parameter int               RES_W       = 10,
    parameter logic [SIG_W-1:0] SIG_VALUE   = 32'h5EC7_91A3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic [RES_W-1:0]  sample_i,
    output logic [CHAN_W-1:0] chan_o,
    output logic              atten_o
);
    logic                            start_w;
    logic                            clr_w;
    logic                            busy_w;
    logic                            done_w;
    logic [RES_W-1:0]                result_w;
    sel_t                            sel_w;
    logic [SIG_BYTES-1:0][BUS_W-1:0] sig_w;

    adcr_sig_rom #(.SIG_VALUE(SIG_VALUE)) u_sig (
        .bytes_o (sig_w)
    );

    adcr_regs #(.RES_W(RES_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .wr_i     (wr_i),
        .rd_i     (rd_i),
        .wdata_i  (wdata_i),
        .done_i   (done_w),
        .result_i (result_w),
        .sig_i    (sig_w),
        .rdata_o  (rdata_o),
        .sel_o    (sel_w),
        .start_o  (start_w),
        .clr_o    (clr_w)
    );

    adcr_seq #(.CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .clr_i    (clr_w),
        .sample_i (sample_i),
        .busy_o   (busy_w),
        .done_o   (done_w),
        .result_o (result_w)
    );

    assign chan_o  = sel_w.chan;
    assign atten_o = sel_w.atten;
endmodule

// File: rtl/adcr_chk.sv
module adcr_chk
    import adcr_pkg::*;
#(
    parameter int               RES_W     = 10,
    parameter logic [SIG_W-1:0] SIG_VALUE = 32'h5EC7_91A3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        addr_i,
    input logic              wr_i,
    input logic              rd_i,
    input logic [7:0]        rdata_o,
    input logic [CHAN_W-1:0] chan_o,
    input logic              atten_o,
    input logic              clr,
    input logic              busy,
    input logic              done,
    input logic [RES_W-1:0]  result
);
    // R3
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_SEL && !clr) |=> !done);

    // R3
    done_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(result)));

    // R9
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_CLEAR) |=> ##1 (!done && !busy && chan_o == '0 && !atten_o));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (addr_i >= A_UNMAP || addr_i == A_CLEAR)) |=> rdata_o == '0);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

    // R7
    sig_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == A_SIG0) |=> rdata_o == SIG_VALUE[7:0]);
endmodule

bind adc_regfile_ctrl adcr_chk #(.RES_W(RES_W), .SIG_VALUE(SIG_VALUE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .rdata_o (rdata_o),
    .chan_o  (chan_o),
    .atten_o (atten_o),
    .clr     (clr_w),
    .busy    (busy_w),
    .done    (done_w),
    .result  (result_w)
);

// File: tb/test_adc_regfile_ctrl.sv
`timescale 1ns/1ps
module test_adc_regfile_ctrl;
    localparam int          N   = 64;
    localparam logic [31:0] SIG = 32'h5EC7_91A3;
    localparam int          WD  = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [9:0] sample = '0;
    logic [3:0] chan;
    logic       atten;

    int checks = 0;
    int failures = 0;
    logic [9:0] last_res;

    always #2.5 clk = ~clk;

    adc_regfile_ctrl #(.CONV_CYCLES(N), .RES_W(10), .SIG_VALUE(SIG)) i_adc_regfile_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .sample_i(sample),
        .chan_o(chan), .atten_o(atten)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 chan_o", 32'(chan), 0);
        check("R1 atten_o", 32'(atten), 0);
        bus_rd(8'h00, v); check("R1 sel", 32'(v), 0);
        bus_rd(8'h01, v); check("R1 low byte", 32'(v), 0);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        sample = 10'h2B5;
        bus_wr(8'h00, 8'hF3);
        check("R2 chan_o", 32'(chan), 3);
        check("R2 atten_o", 32'(atten), 1);
        repeat (N - 1) @(negedge clk);
        bus_rd(8'h01, v); check("R3 done low before edge N", 32'(v[0]), 0);
        bus_rd(8'h01, v); check("R3 done at edge N", 32'(v[0]), 1);
        check("R5 low byte", 32'(v), 32'({sample[6:0], 1'b1}));
        bus_rd(8'h02, v); check("R5 high byte", 32'(v), 32'(sample >> 7));
        bus_rd(8'h00, v); check("R2 sel readback", 32'(v), 32'h13);
        last_res = 10'h2B5;
    endtask

    task automatic t_capture();
        logic [7:0] v;
        sample = 10'h0CA;
        bus_wr(8'h00, 8'h05);
        repeat (N / 2) @(negedge clk);
        sample = 10'h351;
        bus_rd(8'h01, v);
        check("R4 result held while busy", 32'(v), 32'({last_res[6:0], 1'b0}));
        bus_rd(8'h02, v);
        check("R4 high held while busy", 32'(v), 32'(last_res >> 7));
        repeat (N) @(negedge clk);
        bus_rd(8'h01, v);
        check("R4 captured at final cycle lo", 32'(v), 32'({7'h51, 1'b1}));
        bus_rd(8'h02, v);
        check("R4 captured at final cycle hi", 32'(v), 32'(10'h351 >> 7));
        last_res = 10'h351;
    endtask

    task automatic t_restart();
        logic [7:0] v;
        sample = 10'h111;
        bus_wr(8'h00, 8'h01);
        repeat (10) @(negedge clk);
        sample = 10'h3C6;
        bus_wr(8'h00, 8'h12);
        check("R6 new channel", 32'(chan), 2);
        repeat (N - 1) @(negedge clk);
        bus_rd(8'h01, v); check("R6 done held past first finish", 32'(v[0]), 0);
        bus_rd(8'h01, v); check("R6 done after later request", 32'(v[0]), 1);
        check("R6 result lo", 32'(v), 32'({7'h46, 1'b1}));
        bus_rd(8'h02, v); check("R6 result hi", 32'(v), 32'(10'h3C6 >> 7));
        last_res = 10'h3C6;
    endtask

    task automatic t_sig();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin
            bus_rd(8'(4 + i), v);
            check("R7 signature byte", 32'(v), 32'(SIG[i*8 +: 8]));
        end
        bus_wr(8'h06, 8'h00);
        bus_wr(8'h04, 8'hFF);
        bus_rd(8'h06, v); check("R8 sig byte2 unchanged", 32'(v), 32'(SIG[23:16]));
        bus_rd(8'h04, v); check("R8 sig byte0 unchanged", 32'(v), 32'(SIG[7:0]));
        bus_rd(8'h01, v); check("R8 no conversion started", 32'(v), 32'({last_res[6:0], 1'b1}));
        bus_rd(8'h00, v); check("R8 sel unchanged", 32'(v), 32'h12);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        bus_rd(8'h03, v); check("R10 read 0x03", 32'(v), 0);
        bus_rd(8'h08, v); check("R10 read 0x08", 32'(v), 0);
        bus_rd(8'hFF, v); check("R10 read 0xFF", 32'(v), 0);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        bus_rd(8'h05, v);
        addr = 8'h00;
        repeat (3) @(negedge clk);
        check("R11 rdata held without strobe", 32'(rdata), 32'(SIG[15:8]));
    endtask

    task automatic t_clear();
        logic [7:0] v;
        sample = 10'h0F0;
        bus_wr(8'h00, 8'h1A);
        repeat (5) @(negedge clk);
        bus_wr(8'h03, 8'h5A);
        check("R9 sel kept until pulse edge", 32'(chan), 32'hA);
        @(negedge clk);
        check("R9 chan cleared", 32'(chan), 0);
        check("R9 atten cleared", 32'(atten), 0);
        repeat (N + 5) @(negedge clk);
        bus_rd(8'h01, v);
        check("R9 aborted, result kept", 32'(v), 32'({last_res[6:0], 1'b0}));
        bus_rd(8'h00, v); check("R9 sel reads zero", 32'(v), 0);
        bus_wr(8'h00, 8'h04);
        repeat (N + 2) @(negedge clk);
        bus_rd(8'h01, v); check("R9 new conversion after clear", 32'(v), 32'({7'h70, 1'b1}));
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_capture();
        t_restart();
        t_sig();
        t_unmapped();
        t_hold();
        t_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule